// File: doc/BRIEF.md
# OUT Endpoint Receive Buffer Manager

This block manages the storage side of one host-to-device data endpoint. The bus side delivers each packet as a start strobe with its data toggle, a run of byte strobes, and an end strobe with a CRC/bit-stuff error status. The block holds each packet in one of two packet slots. Double buffering is selectable, so either one or two packets can be buffered. For bulk and interrupt traffic it decides the handshake at the end of the packet: ACK, NAK or STALL. For isochronous traffic it sends no handshake. Instead it records a lost packet as an overrun and a damaged packet as a data error.

The CPU side sees a receive-ready flag and the 11-bit byte count of the oldest buffered packet, split into a low byte and a 3-bit high part. A data port presents the next byte of that packet, and each read strobe consumes one byte. Software frees a slot with a release pulse or a flush pulse. Auto-release can instead free the slot by itself once a packet of exactly the maximum size has been read out. The maximum size is programmed in units of 8 bytes.

Top module: `out_ep_rxbuf`

## Requirements
- R1: A stored packet raises `rdy` and gives a one-cycle `irq` pulse in the cycle after its end strobe. The byte count shows the packet's length.
- R2: While `rdy` is high, `rd_data` shows the head packet's bytes in arrival order, and each `rd_strobe` advances one byte. Once all bytes are read, `rd_data` is 0 and further strobes do not advance the position.
- R3: `rel_pulse` frees the head slot. With `auto_rel` set, the slot is freed by itself when the last byte of a packet whose length equals `max_pkt`×8 is read. A shorter packet keeps `rdy` high until it is released.
- R4: `{cnt_hi,cnt_lo}` is the 11-bit byte count of the head packet while `rdy` is high, and 0 otherwise. A zero-length packet sets `rdy` with a count of 0.
- R5: `full` is high when no slot is free. That is one packet with `dbl_buf`=0 and two with `dbl_buf`=1. A bulk packet that arrives while `full` gets NAK (`hs_code`=2) and is not stored.
- R6: In isochronous mode no handshake is issued (`hs_vld` stays 0). A packet that arrives while `full` is dropped and sets `ovr`, which stays set until `clr_ovr`.
- R7: In isochronous mode a packet that ends with `rx_err` is still stored, and `derr` is high with `rdy` for it. `derr` drops when that packet is released.
- R8: `flush_pulse` discards only the head packet. With two packets buffered, the second becomes the head, and a second flush empties the buffer.
- R9: While `stall_hold` is high, a bulk packet gets STALL (`hs_code`=3) and is not stored. The packet sets `sent_stall` and pulses `irq`. `sent_stall` stays set until `clr_sent_stall`, and the expected toggle is unchanged.
- R10: A bulk packet whose toggle equals `tgl_exp` gets ACK (`hs_code`=1), is stored, and flips `tgl_exp`. A mismatched toggle gets ACK but is discarded. A packet ending with `rx_err` is dropped with no handshake. `clr_tgl` sets `tgl_exp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| dbl_buf | input | 1 | 1 = two packet slots in use |
| auto_rel | input | 1 | Free slot after a full-size packet is read |
| max_pkt | input | 8 | Maximum packet size in units of 8 bytes |
| stall_hold | input | 1 | Answer bulk packets with STALL |
| clr_tgl | input | 1 | Reset expected toggle to 0 |
| clr_sent_stall | input | 1 | Clear sent-stall flag |
| clr_ovr | input | 1 | Clear overrun flag |
| rx_start | input | 1 | Packet start strobe |
| rx_tgl | input | 1 | Data toggle of the packet, valid with rx_start |
| rx_byte_vld | input | 1 | Byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Packet end strobe |
| rx_err | input | 1 | CRC or bit-stuff error, valid with rx_end |
| hs_vld | output | 1 | Handshake decision valid (one cycle) |
| hs_code | output | 2 | 1 = ACK, 2 = NAK, 3 = STALL |
| rd_strobe | input | 1 | Consume one byte of the head packet |
| rel_pulse | input | 1 | Release the head packet |
| flush_pulse | input | 1 | Discard the head packet |
| rd_data | output | 8 | Current byte of the head packet |
| rdy | output | 1 | Receive-ready: a packet is buffered |
| full | output | 1 | No free slot |
| cnt_lo | output | 8 | Byte count bits 7:0 |
| cnt_hi | output | 3 | Byte count bits 10:8 |
| ovr | output | 1 | Isochronous overrun flag |
| derr | output | 1 | Isochronous data error of head packet |
| sent_stall | output | 1 | A STALL was sent |
| irq | output | 1 | Interrupt pulse |
| tgl_exp | output | 1 | Expected data toggle |

## Verification
The bench reads one byte past each packet's end. A design that lets the read position run on would return stale bytes, or lose the next packet's first byte. It sends a full-size packet and then a short one under auto-release; a design that compared against the wrong size would free the short packet too early or hold the full one forever. With two packets buffered it checks that a third gets NAK and that one flush leaves the second packet as the head, which catches a flush that empties the whole buffer. It drives mismatched toggles, erroneous bulk packets and stalled packets, and checks that none of them is stored or moves the expected toggle. It also checks that the isochronous overrun and data-error flags follow their own set and clear rules.

// File: rtl/out_ep_rxbuf.sv
module out_ep_rxbuf #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iso_mode,
  input  logic       dbl_buf,
  input  logic       auto_rel,
  input  logic [7:0] max_pkt,
  input  logic       stall_hold,
  input  logic       clr_tgl,
  input  logic       clr_sent_stall,
  input  logic       clr_ovr,
  input  logic       rx_start,
  input  logic       rx_tgl,
  input  logic       rx_byte_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_end,
  input  logic       rx_err,
  output logic       hs_vld,
  output logic [1:0] hs_code,
  input  logic       rd_strobe,
  input  logic       rel_pulse,
  input  logic       flush_pulse,
  output logic [7:0] rd_data,
  output logic       rdy,
  output logic       full,
  output logic [7:0] cnt_lo,
  output logic [2:0] cnt_hi,
  output logic       ovr,
  output logic       derr,
  output logic       sent_stall,
  output logic       irq,
  output logic       tgl_exp
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [10:0] DEPTH_C = 11'(DEPTH);
  localparam logic [1:0] HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3;

  logic [7:0]  mem [2][DEPTH];
  logic [10:0] slot_cnt [2];
  logic [1:0]  slot_err;
  logic        wp, rp;
  logic [1:0]  n;
  logic [10:0] wcnt, rptr;
  logic        busy, acc, stl, pkt_tgl;

  logic [10:0] head_cnt;
  logic        have, auto_hit, release_s, commit, wr_en, stall_evt;

  assign head_cnt  = slot_cnt[rp];
  assign rdy       = (n != 2'd0);
  assign full      = (n == (dbl_buf ? 2'd2 : 2'd1));
  assign have      = rdy && (rptr < head_cnt);
  assign rd_data   = have ? mem[rp][rptr[AW-1:0]] : 8'h00;
  assign {cnt_hi, cnt_lo} = rdy ? head_cnt : 11'd0;
  assign derr      = rdy && slot_err[rp];
  assign auto_hit  = auto_rel && rd_strobe && have &&
                     (rptr + 11'd1 == head_cnt) && (head_cnt == {max_pkt, 3'b000});
  assign release_s = rdy && (rel_pulse || flush_pulse || auto_hit);
  assign commit    = busy && rx_end && acc &&
                     (iso_mode || (!rx_err && pkt_tgl == tgl_exp));
  assign wr_en     = busy && acc && rx_byte_vld && (wcnt < DEPTH_C);
  assign stall_evt = busy && rx_end && !iso_mode && stl;

  always_ff @(posedge clk)
    if (wr_en) mem[wp][wcnt[AW-1:0]] <= rx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_cnt[0] <= '0;
      slot_cnt[1] <= '0;
      slot_err    <= '0;
      wp <= 1'b0; rp <= 1'b0; n <= '0;
      wcnt <= '0; rptr <= '0;
      busy <= 1'b0; acc <= 1'b0; stl <= 1'b0; pkt_tgl <= 1'b0;
      hs_vld <= 1'b0; hs_code <= '0;
      ovr <= 1'b0; sent_stall <= 1'b0; irq <= 1'b0; tgl_exp <= 1'b0;
    end else begin
      hs_vld <= 1'b0;
      irq    <= commit || stall_evt;

      if (rx_start) begin
        busy    <= 1'b1;
        wcnt    <= '0;
        pkt_tgl <= rx_tgl;
        stl     <= stall_hold && !iso_mode;
        acc     <= !full && !(stall_hold && !iso_mode);
      end else if (wr_en) begin
        wcnt <= wcnt + 11'd1;
      end

      if (clr_tgl) tgl_exp <= 1'b0;
      if (clr_ovr) ovr <= 1'b0;
      if (clr_sent_stall) sent_stall <= 1'b0;

      if (busy && rx_end) begin
        busy <= 1'b0;
        acc  <= 1'b0;
        if (iso_mode) begin
          if (!acc) ovr <= 1'b1;
        end else if (stl) begin
          hs_vld <= 1'b1; hs_code <= HS_STALL;
          sent_stall <= 1'b1;
        end else if (!acc) begin
          hs_vld <= 1'b1; hs_code <= HS_NAK;
        end else if (!rx_err) begin
          hs_vld <= 1'b1; hs_code <= HS_ACK;
          if (pkt_tgl == tgl_exp) tgl_exp <= !tgl_exp;
        end
      end

      if (commit) begin
        slot_cnt[wp] <= wcnt;
        slot_err[wp] <= iso_mode && rx_err;
        wp <= !wp;
      end

      if (release_s) begin
        rp   <= !rp;
        rptr <= '0;
      end else if (rd_strobe && have) begin
        rptr <= rptr + 11'd1;
      end

      case ({commit, release_s})
        2'b10:   n <= n + 2'd1;
        2'b01:   n <= n - 2'd1;
        default: ;
      endcase
    end
  end

  p_irq_on_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> irq);
  p_read_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !have && !release_s) |=> $stable(rptr));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (head_cnt <= DEPTH_C));
  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_ovr) |=> ovr);
  p_stall_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_vld && hs_code == HS_STALL) |-> (sent_stall && irq));
  p_tgl_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tgl && !rx_end) |=> !tgl_exp);
endmodule

// File: tb/test_out_ep_rxbuf.sv
module test_out_ep_rxbuf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic iso_mode = 0, dbl_buf = 0, auto_rel = 0, stall_hold = 0;
  logic [7:0] max_pkt = 8'd1;
  logic clr_tgl = 0, clr_sent_stall = 0, clr_ovr = 0;
  logic rx_start = 0, rx_tgl = 0, rx_byte_vld = 0, rx_end = 0, rx_err = 0;
  logic [7:0] rx_byte = 0;
  logic rd_strobe = 0, rel_pulse = 0, flush_pulse = 0;
  logic hs_vld, rdy, full, ovr, derr, sent_stall, irq, tgl_exp;
  logic [1:0] hs_code;
  logic [7:0] rd_data, cnt_lo;
  logic [2:0] cnt_hi;
  int n_run = 0, n_fail = 0;
  logic g_hs_vld, g_irq;
  logic [1:0] g_hs;

  always #5 clk = ~clk;

  out_ep_rxbuf i_out_ep_rxbuf (.*);

  typedef struct packed {
    logic [7:0]  len;
    logic        tgl;
    logic        err;
    logic        hsv;
    logic [1:0]  hs;
    logic        stored;
  } vec_t;
  localparam vec_t VEC [6] = '{
    '{8'd5,  1'b0, 1'b0, 1'b1, 2'd1, 1'b1},
    '{8'd3,  1'b1, 1'b0, 1'b1, 2'd1, 1'b1},
    '{8'd4,  1'b1, 1'b0, 1'b1, 2'd1, 1'b0},
    '{8'd6,  1'b0, 1'b1, 1'b0, 2'd0, 1'b0},
    '{8'd0,  1'b0, 1'b0, 1'b1, 2'd1, 1'b1},
    '{8'd16, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int len, input logic t, input logic e, input logic [7:0] seed);
    @(negedge clk); rx_start = 1; rx_tgl = t;
    @(negedge clk); rx_start = 0;
    for (int i = 0; i < len; i++) begin
      rx_byte_vld = 1; rx_byte = seed + 8'(i);
      @(negedge clk);
    end
    rx_byte_vld = 0; rx_end = 1; rx_err = e;
    @(negedge clk); rx_end = 0; rx_err = 0;
    g_hs_vld = hs_vld; g_hs = hs_code; g_irq = irq;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    chk(req, "rd_data", rd_data, exp);
    rd_strobe = 1; @(negedge clk); rd_strobe = 0;
  endtask

  task automatic rel();
    rel_pulse = 1; @(negedge clk); rel_pulse = 0;
  endtask

  task automatic flush();
    flush_pulse = 1; @(negedge clk); flush_pulse = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset rdy", rdy, 0);
    chk("R5", "reset full", full, 0);
    chk("R4", "reset count", {cnt_hi, cnt_lo}, 0);
    chk("R6", "reset ovr", ovr, 0);
    chk("R9", "reset sent_stall", sent_stall, 0);
    chk("R10", "reset tgl", tgl_exp, 0);

    for (int k = 0; k < 6; k++) begin
      send(int'(VEC[k].len), VEC[k].tgl, VEC[k].err, 8'(k * 32));
      chk("R10", "hs_vld", g_hs_vld, VEC[k].hsv);
      if (VEC[k].hsv) chk("R10", "hs_code", g_hs, VEC[k].hs);
      chk("R1", "rdy", rdy, VEC[k].stored);
      chk("R1", "irq", g_irq, VEC[k].stored);
      if (VEC[k].stored) begin
        chk("R4", "count", {cnt_hi, cnt_lo}, int'(VEC[k].len));
        for (int i = 0; i < int'(VEC[k].len); i++) rd("R2", 8'(k * 32 + i));
        rd("R2", 8'h00);
        chk("R2", "past end data", rd_data, 0);
        chk("R4", "count held", {cnt_hi, cnt_lo}, int'(VEC[k].len));
        rel();
        chk("R3", "released", rdy, 0);
      end
    end
    chk("R10", "toggle after table", tgl_exp, 0);

    auto_rel = 1; max_pkt = 8'd1;
    send(8, 0, 0, 8'h40);
    for (int i = 0; i < 8; i++) rd("R3", 8'h40 + 8'(i));
    chk("R3", "auto release full size", rdy, 0);
    send(5, 1, 0, 8'h50);
    for (int i = 0; i < 5; i++) rd("R3", 8'h50 + 8'(i));
    chk("R3", "short packet kept", rdy, 1);
    rel();
    auto_rel = 0;

    dbl_buf = 1;
    send(4, 0, 0, 8'h60);
    send(2, 1, 0, 8'h70);
    chk("R5", "double full", full, 1);
    chk("R4", "head count", {cnt_hi, cnt_lo}, 4);
    send(3, 0, 0, 8'h80);
    chk("R5", "NAK when full", g_hs, 2);
    chk("R5", "toggle kept on NAK", tgl_exp, 0);
    for (int i = 0; i < 4; i++) rd("R5", 8'h60 + 8'(i));
    rel();
    chk("R5", "second head count", {cnt_hi, cnt_lo}, 2);
    chk("R5", "not full", full, 0);
    rd("R5", 8'h70);
    rel();
    chk("R5", "empty", rdy, 0);

    dbl_buf = 0;
    send(1, 0, 0, 8'h11);
    chk("R5", "single full", full, 1);
    send(1, 1, 0, 8'h12);
    chk("R5", "single NAK", g_hs, 2);
    rel();

    dbl_buf = 1;
    send(3, 1, 0, 8'h20);
    send(5, 0, 0, 8'h30);
    flush();
    chk("R8", "one flush keeps second", rdy, 1);
    chk("R8", "second count", {cnt_hi, cnt_lo}, 5);
    chk("R8", "second first byte", rd_data, 8'h30);
    flush();
    chk("R8", "two flushes empty", rdy, 0);
    dbl_buf = 0;

    stall_hold = 1;
    send(2, 1, 0, 8'h90);
    chk("R9", "STALL code", g_hs, 3);
    chk("R9", "sent_stall", sent_stall, 1);
    chk("R9", "irq on stall", g_irq, 1);
    chk("R9", "not stored", rdy, 0);
    chk("R9", "toggle kept", tgl_exp, 1);
    stall_hold = 0;
    @(negedge clk);
    chk("R9", "sent_stall sticky", sent_stall, 1);
    clr_sent_stall = 1; @(negedge clk); clr_sent_stall = 0;
    chk("R9", "sent_stall cleared", sent_stall, 0);

    clr_tgl = 1; @(negedge clk); clr_tgl = 0;
    chk("R10", "clr_tgl", tgl_exp, 0);
    send(2, 0, 0, 8'hA0);
    chk("R10", "accepted after clear", rdy, 1);
    chk("R10", "toggle flipped", tgl_exp, 1);
    rel();

    iso_mode = 1;
    send(4, 0, 0, 8'hB0);
    chk("R6", "iso no handshake", g_hs_vld, 0);
    chk("R7", "iso stored clean", derr, 0);
    send(2, 1, 0, 8'hC0);
    chk("R6", "iso no handshake when full", g_hs_vld, 0);
    chk("R6", "overrun set", ovr, 1);
    chk("R6", "head unchanged", {cnt_hi, cnt_lo}, 4);
    @(negedge clk);
    chk("R6", "overrun sticky", ovr, 1);
    clr_ovr = 1; @(negedge clk); clr_ovr = 0;
    chk("R6", "overrun cleared", ovr, 0);
    rel();
    send(3, 0, 1, 8'hD0);
    chk("R7", "errored iso stored", rdy, 1);
    chk("R7", "derr with rdy", derr, 1);
    rel();
    chk("R7", "derr clears on release", derr, 0);
    iso_mode = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule